// File: doc/BRIEF.md
# Transmit Holding FIFO with Empty Interrupt

This block is the transmit half of a classic 16550-style serial port. The host writes bytes into a 16-entry first-in first-out store through a holding-register write strobe. A bit serializer drains the store through a valid/ready handshake. The block also raises the "holding register empty" interrupt (THRE) that tells the host to supply more data.

The interrupt does not always rise at the moment the store runs dry. A flag records whether the store has held two or more bytes at once since THRE last rose. If the flag is set when the store empties, THRE rises at once. If the flag is clear, THRE waits for a programmable number of bit-clock ticks, one character time by default. This gives the host a chance to write again before it has to service an interrupt. The interrupt is dropped by any write to the holding register. It is also dropped by an identification read, but only when the identification code supplied with that read is the one for THRE. A synchronous clear empties the store.

Top module: `tx_holding_fifo`

## Requirements
- R1: After reset the store is empty, `level` is 0, `full` and `overflow` are low, and `thre_irq` is high.
- R2: Bytes leave in the order they were written. `tx_valid` is high exactly when `level` is non-zero. `tx_data` shows the oldest byte. A byte is removed on a clock edge where `tx_valid` and `tx_ready` are both high.
- R3: The store holds `DEPTH` (16) bytes. A write while `full` is dropped and `overflow` is high in that same cycle. A write in the same cycle as a pop from a full store is also dropped.
- R4: `tx_ready` while the store is empty changes nothing: `level` stays 0.
- R5: `fifo_clr` empties the store at the next edge. It takes priority over a write and a pop in the same cycle, and it raises no `overflow`.
- R6: Suppose the store has held two or more bytes at once since THRE last rose. In the cycle after the first cycle in which `level` reads 0, `thre_irq` is high, unless a clear from R8 or R9 occurs in that cycle.
- R7: Otherwise, `thre_irq` rises only after `DELAY_TICKS` (10) `bit_tick` pulses have been counted. Counting starts with the cycle after the first cycle in which `level` reads 0, and the store must stay empty throughout. A write cancels the count.
- R8: A cycle with `wr_en` high leaves `thre_irq` low at the next edge.
- R9: An `iid_rd` strobe with `iid_code` = 3'b001 leaves `thre_irq` low at the next edge. With any other code the strobe has no effect.
- R10: `thre_irq` is never high while `level` is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Holding-register write strobe |
| wr_data | input | WIDTH | Byte to enqueue |
| fifo_clr | input | 1 | Transmit store clear request |
| iid_rd | input | 1 | Interrupt identification read strobe |
| iid_code | input | 3 | Identification bits [3:1] presented with the read; 3'b001 means THRE is top priority |
| bit_tick | input | 1 | One pulse per serial bit period |
| tx_ready | input | 1 | Serializer accepts the offered byte |
| tx_valid | output | 1 | A byte is offered to the serializer |
| tx_data | output | WIDTH | Oldest stored byte |
| level | output | $clog2(DEPTH+1) | Number of stored bytes |
| full | output | 1 | Store holds DEPTH bytes |
| empty | output | 1 | Store holds no byte |
| overflow | output | 1 | A write is being dropped this cycle |
| thre_irq | output | 1 | Holding register empty interrupt |

## Verification
The directed patterns come first.
- A single byte written and drained shows the delayed rise. Counting the ticks one short of and exactly at the programmed delay separates the delayed path from the immediate one.
- A 17-byte burst against a stalled serializer, followed by a full drain, exposes ordering and the dropped write. Its final pop separates the immediate rise from the delayed one.
- Identification reads with a wrong code and then the right one tell the priority-gated clear apart from an unconditional clear.
- A clear coinciding with a write checks which of the two wins.

A long stretch of mixed writes, pops, ticks, clears and reads then exercises the occupancy flag across many empty events, compared every cycle against a queue model.

// File: rtl/tx_holding_fifo.sv
module tx_holding_fifo #(
  parameter int DEPTH       = 16,
  parameter int WIDTH       = 8,
  parameter int DELAY_TICKS = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [WIDTH-1:0]           wr_data,
  input  logic                       fifo_clr,
  input  logic                       iid_rd,
  input  logic [2:0]                 iid_code,
  input  logic                       bit_tick,
  input  logic                       tx_ready,
  output logic                       tx_valid,
  output logic [WIDTH-1:0]           tx_data,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       full,
  output logic                       empty,
  output logic                       overflow,
  output logic                       thre_irq
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);
  localparam int TW = $clog2(DELAY_TICKS + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    rd_ptr, wr_ptr;
  logic [LW-1:0]    cnt;
  logic [TW-1:0]    timer;
  logic             held, arm, was_empty;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty    = (cnt == '0);
  assign full     = (cnt == LW'(DEPTH));
  assign level    = cnt;
  assign tx_valid = !empty;
  assign tx_data  = mem[rd_ptr];
  assign overflow = wr_en & full & ~fifo_clr;

  wire push       = wr_en & ~full & ~fifo_clr;
  wire pop        = tx_ready & ~empty & ~fifo_clr;
  wire went_empty = empty & ~was_empty;
  wire thre_clr   = wr_en | (iid_rd & (iid_code == 3'b001));

  always_ff @(posedge clk)
    if (push) mem[wr_ptr] <= wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n || fifo_clr) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thre_irq  <= 1'b1;
      held      <= 1'b0;
      arm       <= 1'b0;
      timer     <= '0;
      was_empty <= 1'b1;
    end else begin
      was_empty <= empty;
      if (cnt >= LW'(2)) held <= 1'b1;
      if (went_empty) begin
        if (held) begin
          thre_irq <= 1'b1;
          held     <= 1'b0;
        end else begin
          arm   <= 1'b1;
          timer <= TW'(DELAY_TICKS);
        end
      end else if (arm) begin
        if (!empty) arm <= 1'b0;
        else if (bit_tick) begin
          if (timer == TW'(1)) begin
            thre_irq <= 1'b1;
            arm      <= 1'b0;
            held     <= 1'b0;
          end else timer <= timer - 1'b1;
        end
      end
      if (thre_clr) thre_irq <= 1'b0;
    end
  end

  a_r3_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
    full && wr_en && !fifo_clr && !tx_ready |=> level == LW'(DEPTH));
  a_r4_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    empty && tx_ready && !wr_en |=> empty);
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> empty && !tx_valid);
  a_r6_immediate: assert property (@(posedge clk) disable iff (!rst_n)
    went_empty && held && !thre_clr |=> thre_irq);
  a_r7_deferred: assert property (@(posedge clk) disable iff (!rst_n)
    went_empty && !held |=> !thre_irq);
  a_r8_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !thre_irq);
  a_r9_iid_clears: assert property (@(posedge clk) disable iff (!rst_n)
    iid_rd && iid_code == 3'b001 |=> !thre_irq);
  a_r10_only_empty: assert property (@(posedge clk) disable iff (!rst_n)
    thre_irq |-> empty);
endmodule

// File: tb/tx_holding_fifo_test.sv
`timescale 1ns/1ps
module tx_holding_fifo_test;
  localparam int DEPTH = 16;
  localparam int DLY   = 10;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, wr_en, fifo_clr, iid_rd, bit_tick, tx_ready;
  logic [7:0] wr_data, tx_data;
  logic [2:0] iid_code;
  logic [4:0] level;
  logic       tx_valid, full, empty, overflow, thre_irq;

  tx_holding_fifo #(.DEPTH(DEPTH), .WIDTH(8), .DELAY_TICKS(DLY)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .fifo_clr(fifo_clr), .iid_rd(iid_rd), .iid_code(iid_code),
    .bit_tick(bit_tick), .tx_ready(tx_ready), .tx_valid(tx_valid),
    .tx_data(tx_data), .level(level), .full(full), .empty(empty),
    .overflow(overflow), .thre_irq(thre_irq));

  int vectors = 0, fails = 0;
  logic [7:0] q[$];
  bit m_thre, m_held, m_arm, m_wasempty;
  int m_timer;

  // behavioural reference model
  always @(posedge clk) begin
    int c;
    bit psh, pp, edge_e, nthre, nheld, narm;
    int ntimer;
    if (!rst_n) begin
      q.delete(); m_thre = 1; m_held = 0; m_arm = 0; m_timer = 0; m_wasempty = 1;
    end else begin
      c = q.size();
      psh = wr_en && c < DEPTH && !fifo_clr;
      pp = tx_ready && c > 0 && !fifo_clr;
      edge_e = (c == 0) && !m_wasempty;
      nthre = m_thre; nheld = m_held || c >= 2; narm = m_arm; ntimer = m_timer;
      if (edge_e) begin
        if (m_held) begin nthre = 1; nheld = 0; end
        else begin narm = 1; ntimer = DLY; end
      end else if (m_arm) begin
        if (c != 0) narm = 0;
        else if (bit_tick) begin
          if (m_timer == 1) begin nthre = 1; narm = 0; nheld = 0; end
          else ntimer = m_timer - 1;
        end
      end
      if (wr_en || (iid_rd && iid_code == 3'b001)) nthre = 0;
      m_thre = nthre; m_held = nheld; m_arm = narm; m_timer = ntimer;
      m_wasempty = (c == 0);
      if (fifo_clr) q.delete();
      else begin
        if (pp) void'(q.pop_front());
        if (psh) q.push_back(wr_data);
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    vectors++;
    check("R2 level", level, q.size());
    check("R2 tx_valid", tx_valid, q.size() > 0);
    if (q.size() > 0) check("R2 tx_data", tx_data, q[0]);
    check("R3 full", full, q.size() == DEPTH);
    check("R4 empty", empty, q.size() == 0);
    check("R3 overflow", overflow, wr_en && q.size() == DEPTH && !fifo_clr);
    check("R6/R7/R8/R9 thre_irq", thre_irq, m_thre);
    if (thre_irq && level != 0) check("R10 thre_irq while occupied", 1, 0);
  endtask

  task automatic step(input bit w, input logic [7:0] d, input bit rdy, input bit clr,
                      input bit rd, input logic [2:0] code, input bit tick);
    @(negedge clk);
    wr_en = w; wr_data = d; tx_ready = rdy; fifo_clr = clr;
    iid_rd = rd; iid_code = code; bit_tick = tick;
    #1 compare();
  endtask

  task automatic idle(); step(0, 8'h00, 0, 0, 0, 3'b000, 0); endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    rst_n = 0; wr_en = 0; wr_data = 0; fifo_clr = 0; iid_rd = 0;
    iid_code = 0; bit_tick = 0; tx_ready = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R1: reset state
    idle();
    check("R1 thre_irq", thre_irq, 1);
    check("R1 level", level, 0);
    check("R1 overflow", overflow, 0);

    // R8 write clears, R7 delayed rise after a single byte
    step(1, 8'hA5, 0, 0, 0, 3'b000, 0);
    idle();
    check("R8 thre_irq after write", thre_irq, 0);
    step(0, 8'h00, 1, 0, 0, 3'b000, 0);
    idle();
    check("R7 level drained", level, 0);
    for (int i = 0; i < DLY - 1; i++) step(0, 8'h00, 0, 0, 0, 3'b000, 1);
    idle();
    check("R7 thre_irq one tick short", thre_irq, 0);
    step(0, 8'h00, 0, 0, 0, 3'b000, 1);
    idle();
    check("R7 thre_irq after delay", thre_irq, 1);

    // R3 fill and overflow, R2 order, R6 immediate rise
    for (int i = 0; i < DEPTH + 1; i++) step(1, 8'(8'h10 + i), 0, 0, 0, 3'b000, 0);
    check("R3 overflow on 17th write", overflow, 1);
    idle();
    check("R3 level full", level, DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      step(0, 8'h00, 1, 0, 0, 3'b000, 0);
      check("R2 drain order", tx_data, 8'h10 + i);
    end
    idle();
    check("R6 level drained", level, 0);
    idle();
    check("R6 immediate thre_irq", thre_irq, 1);

    // R4 pops on empty
    for (int i = 0; i < 4; i++) step(0, 8'h00, 1, 0, 0, 3'b000, 0);
    idle();
    check("R4 level after empty pops", level, 0);

    // R9 identification read
    step(0, 8'h00, 0, 0, 1, 3'b010, 0);
    idle();
    check("R9 wrong code ignored", thre_irq, 1);
    step(0, 8'h00, 0, 0, 1, 3'b001, 0);
    idle();
    check("R9 thre code clears", thre_irq, 0);

    // R5 clear beats write
    for (int i = 0; i < 5; i++) step(1, 8'(8'h40 + i), 0, 0, 0, 3'b000, 0);
    step(1, 8'h99, 1, 1, 0, 3'b000, 0);
    check("R5 no overflow on clear", overflow, 0);
    idle();
    check("R5 level after clear", level, 0);

    // mixed traffic
    for (int i = 0; i < 6000; i++) begin
      int ph = (i / 500) % 3;
      bit w = (ph == 0) ? ($urandom % 4 != 0) : (ph == 1) ? ($urandom % 8 == 0) : ($urandom % 2 == 0);
      bit r = (ph == 0) ? ($urandom % 4 == 0) : ($urandom % 2 == 0);
      step(w, 8'($urandom), r, ($urandom % 200 == 0), ($urandom % 16 == 0),
           3'($urandom), ($urandom % 3 == 0));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule